// File: doc/BRIEF.md
# USB Descriptor Memory Gatekeeper and Loader

This block keeps the descriptor table of a USB function controller in a 384-byte memory. A CPU reaches that memory through a register window at byte addresses 0x500 to 0x67F, with one byte at each address. The block opens that window at two times only. The first is before the first bus reset is seen. The second is while a Set Descriptor control request is being served. At any other time, accesses to the window are refused and a sticky error flag records the refusal.

When a bus reset is detected, or when the initialise command is issued, the block streams the whole memory out to the controller core on a load port. It sends one byte per clock, in ascending address order. CPU access to the memory is shut for as long as that stream is running.

The block also holds a write-only policy bit. When the bit is set, the block answers the data and status stages of a Set Descriptor request with STALL on its own. When the bit is clear, the CPU handles those stages. The block also raises a one-cycle interrupt when the status stage ends normally.

Top module: `usb_desc_ram_ctl`

## Requirements
- R1: After reset, `load_busy`, `load_valid`, `load_done`, `auto_stall`, `access_err`, `status_irq` and `cpu_rdata` are all 0, and the stall policy bit is 0.
- R2: Before the first `bus_reset`, a CPU write to an address in 0x500..0x67F stores the byte at offset (address − 0x500). A CPU read returns the stored byte on `cpu_rdata` one clock after the read strobe.
- R3: After a bus reset, and with no Set Descriptor request open, CPU writes to 0x500..0x67F leave the memory unchanged. Reads from that range return 0x00, and `access_err` becomes 1 and stays 1 until reset.
- R4: A `setup_irq` pulse with `req_set_desc`=1 opens the Set Descriptor window from the next clock, and the memory is readable and writable while it is open. An `eop_access` pulse closes the window. A `setup_irq` pulse with `req_set_desc`=0 does not open it.
- R5: A `bus_reset` pulse sets `load_busy` in the next clock. The block then emits 384 `load_valid` beats on consecutive clocks, with `load_addr` running from 0 to 383 and `load_data` equal to the stored byte at that offset. `load_done` is high together with the last beat only, and `load_busy` falls on the same edge.
- R6: An `init_cmd` pulse starts exactly the same load sequence as a bus reset does.
- R7: While `load_busy` is 1, CPU accesses to 0x500..0x67F are refused in the same way as in R3, and the refusal sets `access_err`.
- R8: A CPU write to 0x7E8 loads data bit 0 into the stall policy bit, whether the memory window is open or not. `auto_stall` is 1 exactly when all three of these hold: a Set Descriptor request is open, the policy bit is 1, and `ctl_stage` is data (2'b01) or status (2'b10). The other stage codes are setup (2'b00) and idle (2'b11).
- R9: After an `eop_access` pulse that closes a Set Descriptor request, the next `status_ok` pulse raises `status_irq` for exactly one clock, in the cycle after that pulse. A `status_ok` pulse with nothing pending raises nothing.
- R10: A CPU write inside an open window takes effect even when `bus_reset` is asserted in the same cycle. The load that this bus reset starts streams the newly written byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cpu_addr | input | 12 | CPU byte address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_wr | input | 1 | CPU write strobe, one clock per access |
| cpu_rd | input | 1 | CPU read strobe, one clock per access |
| cpu_rdata | output | 8 | CPU read data, valid one clock after `cpu_rd` |
| bus_reset | input | 1 | Pulse: a USB bus reset was detected |
| init_cmd | input | 1 | Pulse: the initialise-descriptor command was written |
| setup_irq | input | 1 | Pulse: the setup interrupt asserts |
| req_set_desc | input | 1 | The current setup packet decodes to Set Descriptor |
| eop_access | input | 1 | Pulse: the CPU accessed the EOP register |
| status_ok | input | 1 | Pulse: the status stage ended normally |
| ctl_stage | input | 2 | Control transfer stage: 0 setup, 1 data, 2 status, 3 idle |
| load_valid | output | 1 | A descriptor byte is on the load port |
| load_addr | output | 9 | Offset of the byte on the load port |
| load_data | output | 8 | Descriptor byte on the load port |
| load_busy | output | 1 | A load sequence is running |
| load_done | output | 1 | One-clock pulse with the last load beat |
| auto_stall | output | 1 | Answer the current stage with STALL |
| access_err | output | 1 | Sticky flag: a memory access was refused |
| status_irq | output | 1 | One-clock status-stage-done interrupt |

## Verification
A CPU write and the bus reset that closes the pre-reset window can fall in the same cycle. The bench drives a write of 0xA5 to the last byte in the same clock as the `bus_reset` pulse. Its scoreboard expects the new value on beat 383 of the load that follows, because the window decision uses the state as it stood before that edge. Refused accesses also overlap with the load stream. A write and a read are issued in the middle of an `init_cmd` load. The bench expects the stream to be unchanged, the read to return 0x00, and the stored byte to be intact afterwards.

// File: rtl/usb_desc_pkg.sv
package usb_desc_pkg;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 8;
  localparam int DEPTH  = 384;
  localparam int IDX_W  = $clog2(DEPTH);

  localparam logic [ADDR_W-1:0] RAM_BASE  = 12'h500;
  localparam logic [ADDR_W-1:0] RAM_TOP   = ADDR_W'(int'(RAM_BASE) + DEPTH - 1);
  localparam logic [ADDR_W-1:0] STALL_REG = 12'h7E8;
  localparam logic [IDX_W-1:0]  LAST_IDX  = IDX_W'(DEPTH - 1);

  typedef enum logic [1:0] {
    STG_SETUP  = 2'd0,
    STG_DATA   = 2'd1,
    STG_STATUS = 2'd2,
    STG_IDLE   = 2'd3
  } ctl_stage_e;
endpackage

// File: rtl/usb_desc_rst_sync.sv
module usb_desc_rst_sync (
  input  logic clk,
  input  logic rst_n_async,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_async) begin
    if (!rst_n_async) sync_q <= 2'b00;
    else              sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/usb_desc_mem.sv
module usb_desc_mem #(
  parameter int DEPTH  = 384,
  parameter int DATA_W = 8,
  parameter int IDX_W  = 9
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [IDX_W-1:0]  raddr_a,
  output logic [DATA_W-1:0] rdata_a,
  input  logic [IDX_W-1:0]  raddr_b,
  output logic [DATA_W-1:0] rdata_b
);
  logic [DATA_W-1:0] store [DEPTH];

  // contents undefined after reset: no reset on the array
  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
  end

  assign rdata_a = store[raddr_a];
  assign rdata_b = store[raddr_b];
endmodule

// File: rtl/usb_desc_loader.sv
module usb_desc_loader
  import usb_desc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_req,
  output logic [IDX_W-1:0]  mem_raddr,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              busy,
  output logic              ld_valid,
  output logic [IDX_W-1:0]  ld_addr,
  output logic [DATA_W-1:0] ld_data,
  output logic              ld_done
);
  logic              busy_q, busy_d;
  logic [IDX_W-1:0]  cnt_q, cnt_d;
  logic              vld_q, done_q;
  logic [IDX_W-1:0]  addr_q;
  logic [DATA_W-1:0] data_q;
  logic              start, at_last;

  assign start   = start_req && !busy_q;
  assign at_last = (cnt_q == LAST_IDX);

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    if (start) begin
      busy_d = 1'b1;
      cnt_d  = '0;
    end else if (busy_q) begin
      cnt_d = cnt_q + 1'b1;
      if (at_last) busy_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      vld_q  <= 1'b0;
      done_q <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
      vld_q  <= busy_q;
      done_q <= busy_q && at_last;
      if (busy_q) begin
        addr_q <= cnt_q;
        data_q <= mem_rdata;
      end
    end
  end

  assign mem_raddr = cnt_q;
  assign busy      = busy_q;
  assign ld_valid  = vld_q;
  assign ld_addr   = addr_q;
  assign ld_data   = data_q;
  assign ld_done   = done_q;

  // R5
  last_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_done |-> (ld_valid && ld_addr == LAST_IDX));
  // R5
  beat_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && !ld_done) |=> (ld_valid && ld_addr == $past(ld_addr) + 1'b1));
  // R6
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_req && !busy) |=> busy);
endmodule

// File: rtl/usb_desc_window.sv
module usb_desc_window
  import usb_desc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic              cpu_wr,
  input  logic              cpu_rd,
  output logic [DATA_W-1:0] cpu_rdata,
  input  logic              bus_reset,
  input  logic              init_cmd,
  input  logic              setup_irq,
  input  logic              req_set_desc,
  input  logic              eop_access,
  input  logic              status_ok,
  input  logic [1:0]        ctl_stage,
  input  logic              loader_busy,
  output logic              load_req,
  output logic              mem_we,
  output logic [IDX_W-1:0]  mem_addr,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              auto_stall,
  output logic              access_err,
  output logic              status_irq
);
  logic              seen_q, sd_q, stall_q, pend_q, err_q, irq_q;
  logic              seen_d, sd_d, stall_d, pend_d, err_d;
  logic [DATA_W-1:0] rdata_q, rdata_d;
  logic [ADDR_W-1:0] offset_full;
  logic              in_ram, win_open, rd_ok, stall_hit;
  logic              unused_bits;
  ctl_stage_e        stg;

  assign stg         = ctl_stage_e'(ctl_stage);
  assign in_ram      = (cpu_addr >= RAM_BASE) && (cpu_addr <= RAM_TOP);
  assign offset_full = cpu_addr - RAM_BASE;
  assign mem_addr    = offset_full[IDX_W-1:0];
  assign unused_bits = ^{offset_full[ADDR_W-1:IDX_W], cpu_wdata[DATA_W-1:1]};
  assign win_open    = (!seen_q || sd_q) && !loader_busy;
  assign mem_we      = cpu_wr && in_ram && win_open;
  assign rd_ok       = cpu_rd && in_ram && win_open;
  assign stall_hit   = cpu_wr && (cpu_addr == STALL_REG);
  assign load_req    = bus_reset || init_cmd;

  always_comb begin
    seen_d  = seen_q || bus_reset;
    stall_d = stall_hit ? cpu_wdata[0] : stall_q;
    err_d   = err_q || ((cpu_wr || cpu_rd) && in_ram && !win_open);
    rdata_d = rd_ok ? mem_rdata : '0;
    sd_d    = sd_q;
    if (setup_irq && req_set_desc)   sd_d = 1'b1;
    else if (eop_access || bus_reset) sd_d = 1'b0;
    pend_d  = pend_q;
    if (eop_access && sd_q) pend_d = 1'b1;
    else if (status_ok)     pend_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q  <= 1'b0;
      sd_q    <= 1'b0;
      stall_q <= 1'b0;
      pend_q  <= 1'b0;
      err_q   <= 1'b0;
      irq_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      seen_q  <= seen_d;
      sd_q    <= sd_d;
      stall_q <= stall_d;
      pend_q  <= pend_d;
      err_q   <= err_d;
      irq_q   <= status_ok && pend_q;
      if (cpu_rd) rdata_q <= rdata_d;
    end
  end

  assign cpu_rdata  = rdata_q;
  assign access_err = err_q;
  assign status_irq = irq_q;
  assign auto_stall = sd_q && stall_q && (stg == STG_DATA || stg == STG_STATUS);

  // R3
  closed_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && !sd_q) |-> !mem_we);
  // R7
  busy_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    loader_busy |-> !mem_we);
  // R4
  window_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (setup_irq && req_set_desc) |=> sd_q);
  // R8
  stall_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall_hit |=> (stall_q == $past(cpu_wdata[0])));
  // R9
  irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status_irq |=> !status_irq);
endmodule

// File: rtl/usb_desc_ram_ctl.sv
module usb_desc_ram_ctl
  import usb_desc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic              cpu_wr,
  input  logic              cpu_rd,
  output logic [DATA_W-1:0] cpu_rdata,
  input  logic              bus_reset,
  input  logic              init_cmd,
  input  logic              setup_irq,
  input  logic              req_set_desc,
  input  logic              eop_access,
  input  logic              status_ok,
  input  logic [1:0]        ctl_stage,
  output logic              load_valid,
  output logic [IDX_W-1:0]  load_addr,
  output logic [DATA_W-1:0] load_data,
  output logic              load_busy,
  output logic              load_done,
  output logic              auto_stall,
  output logic              access_err,
  output logic              status_irq
);
  logic              rst_n_s;
  logic              busy, load_req, mem_we;
  logic [IDX_W-1:0]  cpu_idx, ld_idx;
  logic [DATA_W-1:0] cpu_mem_data, ld_mem_data;

  usb_desc_rst_sync u_rst (
    .clk(clk), .rst_n_async(rst_n), .rst_n_sync(rst_n_s)
  );

  usb_desc_mem #(.DEPTH(DEPTH), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_mem (
    .clk(clk), .we(mem_we), .waddr(cpu_idx), .wdata(cpu_wdata),
    .raddr_a(cpu_idx), .rdata_a(cpu_mem_data),
    .raddr_b(ld_idx),  .rdata_b(ld_mem_data)
  );

  usb_desc_window u_win (
    .clk(clk), .rst_n(rst_n_s),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd),
    .cpu_rdata(cpu_rdata), .bus_reset(bus_reset), .init_cmd(init_cmd),
    .setup_irq(setup_irq), .req_set_desc(req_set_desc), .eop_access(eop_access),
    .status_ok(status_ok), .ctl_stage(ctl_stage), .loader_busy(busy),
    .load_req(load_req), .mem_we(mem_we), .mem_addr(cpu_idx),
    .mem_rdata(cpu_mem_data), .auto_stall(auto_stall), .access_err(access_err),
    .status_irq(status_irq)
  );

  usb_desc_loader u_load (
    .clk(clk), .rst_n(rst_n_s), .start_req(load_req),
    .mem_raddr(ld_idx), .mem_rdata(ld_mem_data), .busy(busy),
    .ld_valid(load_valid), .ld_addr(load_addr), .ld_data(load_data),
    .ld_done(load_done)
  );

  assign load_busy = busy;
endmodule

// File: tb/usb_desc_ram_ctl_tb.sv
module usb_desc_ram_ctl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic        cpu_wr = 0, cpu_rd = 0, bus_reset = 0, init_cmd = 0;
  logic        setup_irq = 0, req_set_desc = 0, eop_access = 0, status_ok = 0;
  logic [1:0]  ctl_stage = 2'd3;
  logic [7:0]  cpu_rdata, load_data;
  logic [8:0]  load_addr;
  logic        load_valid, load_busy, load_done, auto_stall, access_err, status_irq;

  int vecs = 0;
  int miss = 0;
  logic [7:0]  model [384];
  logic [16:0] exp_q [$];
  logic [7:0]  rv;

  always #4 clk = ~clk;

  usb_desc_ram_ctl u_dut (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      miss++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cpu_write(input logic [11:0] a, input logic [7:0] d);
    @(negedge clk); cpu_addr = a; cpu_wdata = d; cpu_wr = 1;
    @(negedge clk); cpu_wr = 0;
  endtask

  task automatic cpu_read(input logic [11:0] a, output logic [7:0] d);
    @(negedge clk); cpu_addr = a; cpu_rd = 1;
    @(negedge clk); cpu_rd = 0; d = cpu_rdata;
  endtask

  task automatic pulse(ref logic sig);
    @(negedge clk); sig = 1;
    @(negedge clk); sig = 0;
  endtask

  // driver side of the scoreboard: expected load stream
  task automatic push_load();
    for (int i = 0; i < 384; i++) exp_q.push_back({i[8:0], model[i]});
  endtask

  task automatic drain(input string tag);
    for (int n = 0; n < 1000 && exp_q.size() != 0; n++) @(negedge clk);
    chk({tag, " stream drained"}, exp_q.size(), 0);
    @(negedge clk);
    chk({tag, " busy low after last beat"}, load_busy, 0);
  endtask

  // monitor side of the scoreboard
  always @(negedge clk) begin
    if (load_valid) begin
      if (exp_q.size() == 0) chk("R5 unexpected beat", 1, 0);
      else begin
        logic [16:0] e;
        e = exp_q.pop_front();
        chk("R5 beat offset", load_addr, e[16:8]);
        chk("R5 beat data", load_data, e[7:0]);
        chk("R5 done with last beat only", load_done, exp_q.size() == 0);
      end
    end
  end

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    vecs++; miss++;
    $display("FAIL watchdog: actual hung expected finish");
    finish_run();
  end

  initial begin
    #30 rst_n = 1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk("R1 busy", load_busy, 0);
    chk("R1 valid", load_valid, 0);
    chk("R1 done", load_done, 0);
    chk("R1 stall", auto_stall, 0);
    chk("R1 err", access_err, 0);
    chk("R1 irq", status_irq, 0);
    chk("R1 rdata", cpu_rdata, 0);

    // R2 fill in pre-reset window
    for (int i = 0; i < 384; i++) begin
      model[i] = 8'((i * 7 + 3) & 8'hFF);
      cpu_write(12'h500 + 12'(i), model[i]);
    end
    cpu_read(12'h500, rv); chk("R2 read first byte", rv, model[0]);
    cpu_read(12'h67F, rv); chk("R2 read last byte", rv, model[383]);
    cpu_read(12'h5A0, rv); chk("R2 read middle byte", rv, model[160]);
    chk("R2 no error", access_err, 0);

    // R10 write and bus reset in the same cycle
    @(negedge clk); cpu_addr = 12'h67F; cpu_wdata = 8'hA5; cpu_wr = 1; bus_reset = 1;
    model[383] = 8'hA5;
    push_load();
    @(negedge clk); cpu_wr = 0; bus_reset = 0;
    chk("R5 busy after bus reset", load_busy, 1);
    drain("R10 R5");

    // R4 setup without Set Descriptor decode keeps window shut
    @(negedge clk); setup_irq = 1; req_set_desc = 0;
    @(negedge clk); setup_irq = 0;
    cpu_read(12'h501, rv); chk("R4 not opened by other request", rv, 0);
    // that refused read sets the sticky flag
    chk("R3 err after refused read", access_err, 1);

    // R4 open window
    @(negedge clk); setup_irq = 1; req_set_desc = 1;
    @(negedge clk); setup_irq = 0; req_set_desc = 0;
    cpu_write(12'h501, 8'h5A); model[1] = 8'h5A;
    cpu_read(12'h501, rv); chk("R4 write in window", rv, 8'h5A);

    // R8 stall policy
    cpu_write(12'h7E8, 8'h01);
    @(negedge clk); ctl_stage = 2'd1;
    @(negedge clk); chk("R8 stall in data stage", auto_stall, 1);
    ctl_stage = 2'd2;
    @(negedge clk); chk("R8 stall in status stage", auto_stall, 1);
    ctl_stage = 2'd0;
    @(negedge clk); chk("R8 no stall in setup stage", auto_stall, 0);
    ctl_stage = 2'd3;
    @(negedge clk); chk("R8 no stall idle", auto_stall, 0);

    // R7 refused access during load
    ctl_stage = 2'd1;
    @(negedge clk); init_cmd = 1;
    push_load();
    @(negedge clk); init_cmd = 0;
    chk("R6 busy after init", load_busy, 1);
    repeat (20) @(negedge clk);
    cpu_write(12'h502, 8'hEE);
    cpu_read(12'h502, rv); chk("R7 read during load", rv, 0);
    drain("R6");
    cpu_read(12'h502, rv); chk("R7 byte intact after refused write", rv, model[2]);

    // R8 clearing the bit
    cpu_write(12'h7E8, 8'h00);
    @(negedge clk); chk("R8 bit cleared stops stall", auto_stall, 0);
    cpu_write(12'h7E8, 8'h01);
    @(negedge clk); chk("R8 bit set again", auto_stall, 1);

    // R9 status done
    @(negedge clk); status_ok = 1;
    @(negedge clk); status_ok = 0;
    chk("R9 no irq without pending", status_irq, 0);
    pulse(eop_access);
    @(negedge clk); chk("R8 stall ends with request", auto_stall, 0);
    cpu_read(12'h501, rv); chk("R4 closed by eop", rv, 0);
    @(negedge clk); status_ok = 1;
    @(negedge clk); status_ok = 0;
    chk("R9 irq raised", status_irq, 1);
    @(negedge clk); chk("R9 irq one clock", status_irq, 0);
    ctl_stage = 2'd3;

    // R3 closed window after reset
    cpu_write(12'h500, 8'h11);
    cpu_read(12'h500, rv); chk("R3 read closed", rv, 0);
    chk("R3 err sticky", access_err, 1);
    // R6 second load shows byte 0 untouched by R3 write
    @(negedge clk); init_cmd = 1;
    push_load();
    @(negedge clk); init_cmd = 0;
    drain("R6 R3");

    finish_run();
  end
endmodule